// File: doc/BRIEF.md
# Clock-Edge Count Transfer Controller

This controller bounds a synchronous card transfer to a number of card-clock cycles that software picks. Software writes an 8-bit limit through a load strobe. The controller then counts falling card-clock edges, which arrive as single-cycle strobes. While the count is below the limit, it keeps the data path's shift enable high. When the last edge is counted, the controller drops the shift enable, reports done and raises a sticky interrupt flag. It then stays stopped until the next load.

A limit of zero disables counting and puts the data path in its bypass condition. When the card clock restarts from a high park, the first falling edge is only a return to low and must not move data. Software or the clock logic signals such a restart with a strobe. If the counter is armed and has not counted any edge yet, that next edge is dropped.

Top module: `edge_cnt_ctrl`

## Requirements
- R1: After reset, bypass_o=1, shift_en_o=0, done_o=0 and irq_o=0.
- R2: The cycle after a load with a nonzero value, shift_en_o=1, done_o=0 and bypass_o=0.
- R3: A load value of 0 sets bypass_o=1 and shift_en_o=0. Falling-edge strobes then never set done_o or the interrupt flag.
- R4: On the falling edge that brings the count to the loaded limit, shift_en_o falls, done_o rises and the interrupt flag sets, all at the same clock.
- R5: shift_en_o stays high for the first limit-1 edges. Once done, further edges change nothing until the next load.
- R6: irq_o is the flag ANDed with irq_en_i. A masked flag is kept and appears as soon as the enable is set.
- R7: irq_clr_i clears the flag. A completion in the same cycle as a clear leaves the flag set.
- R8: A load while counting restarts from zero with the new limit. A falling edge in the same cycle as a load is not counted.
- R9: A restart_hi_i strobe while armed with a count of zero drops shift_en_o, and the next falling edge is not counted. After that edge, shift_en_o returns high. A restart strobe after at least one counted edge has no effect.
- R10: A limit of 255 completes on exactly the 255th edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| load_i | input | 1 | Load strobe for the edge limit |
| load_val_i | input | 8 | Edge limit; 0 disables counting |
| fall_i | input | 1 | One-cycle strobe per falling card-clock edge |
| restart_hi_i | input | 1 | Strobe: card clock restarted from a high park |
| irq_en_i | input | 1 | Interrupt enable (mask) |
| irq_clr_i | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| irq_o | output | 1 | Masked interrupt |
| done_o | output | 1 | Limit reached; waiting for reload |
| bypass_o | output | 1 | Counting disabled; data path in bypass |
| shift_en_o | output | 1 | Enable for the serializer and FIFO to advance |

## Verification
Two pairs of events can fall in the same clock cycle. The bench drives both strobes of each pair on the same clock. In the first pair, the completing falling edge meets an interrupt clear. The bench then requires the flag to survive. In the second pair, a load meets a falling edge. The bench judges this by counting how many further edges the new limit needs before done_o rises. A restart strobe is also tested both before and after the first counted edge, and the edge count to completion is compared in each case.

// File: rtl/edge_cnt_pkg.sv
package edge_cnt_pkg;
  typedef enum logic [1:0] {
    ST_BYPASS = 2'd0,
    ST_RUN    = 2'd1,
    ST_SKIP   = 2'd2,
    ST_DONE   = 2'd3
  } ctl_st_e;
endpackage

// File: rtl/edge_cnt_core.sv
module edge_cnt_core
  import edge_cnt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             fall_i,
  input  logic             restart_i,
  output ctl_st_e          st_o,
  output logic             hit_o
);
  ctl_st_e          st_q, st_d;
  logic [CNT_W-1:0] count_q, count_d, limit_q, limit_d, count_inc;

  assign count_inc = count_q + 1'b1;

  always_comb begin
    st_d    = st_q;
    count_d = count_q;
    limit_d = limit_q;
    hit_o   = 1'b0;
    if (load_i) begin
      limit_d = load_val_i;
      count_d = '0;
      st_d    = (load_val_i == '0) ? ST_BYPASS : ST_RUN;
    end else begin
      unique case (st_q)
        ST_RUN: begin
          // high-park restart before any counted edge: drop the next edge
          if (restart_i && count_q == '0) begin
            st_d = ST_SKIP;
          end else if (fall_i) begin
            count_d = count_inc;
            if (count_inc == limit_q) begin
              st_d  = ST_DONE;
              hit_o = 1'b1;
            end
          end
        end
        ST_SKIP: if (fall_i) st_d = ST_RUN;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_BYPASS;
      count_q <= '0;
      limit_q <= '0;
    end else begin
      st_q    <= st_d;
      count_q <= count_d;
      limit_q <= limit_d;
    end
  end

  assign st_o = st_q;

  // R5
  count_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_RUN |-> count_q < limit_q);
  // R5
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_DONE && !load_i) |=> (st_q == ST_DONE && $stable(count_q)));
  // R9
  skip_no_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SKIP && !load_i) |=> count_q == $past(count_q));
  // R8
  load_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (count_q == '0 && limit_q == $past(load_val_i)));
endmodule

// File: rtl/edge_cnt_irq.sv
module edge_cnt_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic en_i,
  output logic irq_o
);
  logic flag_q;

  // set wins over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    flag_q <= 1'b0;
    else if (set_i) flag_q <= 1'b1;
    else if (clr_i) flag_q <= 1'b0;
  end

  assign irq_o = flag_q & en_i;

  // R7
  set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  // R7
  clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !flag_q);
  // R6
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/edge_cnt_ctrl.sv
module edge_cnt_ctrl
  import edge_cnt_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             fall_i,
  input  logic             restart_hi_i,
  input  logic             irq_en_i,
  input  logic             irq_clr_i,
  output logic             irq_o,
  output logic             done_o,
  output logic             bypass_o,
  output logic             shift_en_o
);
  ctl_st_e st;
  logic    hit;

  edge_cnt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_i),
    .load_val_i (load_val_i),
    .fall_i     (fall_i),
    .restart_i  (restart_hi_i),
    .st_o       (st),
    .hit_o      (hit)
  );

  edge_cnt_irq u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (hit),
    .clr_i  (irq_clr_i),
    .en_i   (irq_en_i),
    .irq_o  (irq_o)
  );

  assign bypass_o   = (st == ST_BYPASS);
  assign shift_en_o = (st == ST_RUN);
  assign done_o     = (st == ST_DONE);

  // R4
  done_from_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(shift_en_o));
  // R3
  bypass_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bypass_o && !load_i) |=> (bypass_o && !done_o));
endmodule

// File: tb/edge_cnt_ctrl_test.sv
`timescale 1ns/1ps
module edge_cnt_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [7:0] load_val = '0;
  logic       fall = 1'b0;
  logic       restart = 1'b0;
  logic       irq_en = 1'b0;
  logic       irq_clr = 1'b0;
  logic       irq, done, bypass, shift_en;
  int         errors = 0;
  int         checks = 0;

  always #2 clk = ~clk;

  edge_cnt_ctrl uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .load_i       (load),
    .load_val_i   (load_val),
    .fall_i       (fall),
    .restart_hi_i (restart),
    .irq_en_i     (irq_en),
    .irq_clr_i    (irq_clr),
    .irq_o        (irq),
    .done_o       (done),
    .bypass_o     (bypass),
    .shift_en_o   (shift_en)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic do_load(input logic [7:0] v, input logic with_edge);
    @(negedge clk); load = 1'b1; load_val = v; fall = with_edge;
    @(negedge clk); load = 1'b0; fall = 1'b0;
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); fall = 1'b1;
      @(negedge clk); fall = 1'b0;
    end
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "bypass", bypass, 1'b1);
    chk("R1", "shift_en", shift_en, 1'b0);
    chk("R1", "done", done, 1'b0);
    chk("R1", "irq", irq, 1'b0);
  endtask

  task automatic t_basic();
    irq_en = 1'b1;
    do_load(8'd3, 1'b0);
    chk("R2", "shift_en", shift_en, 1'b1);
    chk("R2", "done", done, 1'b0);
    chk("R2", "bypass", bypass, 1'b0);
    edges(2);
    chk("R5", "shift_en mid", shift_en, 1'b1);
    chk("R5", "irq mid", irq, 1'b0);
    edges(1);
    chk("R4", "shift_en end", shift_en, 1'b0);
    chk("R4", "done end", done, 1'b1);
    chk("R4", "irq end", irq, 1'b1);
    edges(3);
    chk("R5", "done after extra", done, 1'b1);
    chk("R5", "shift_en after extra", shift_en, 1'b0);
    clear_irq();
    chk("R7", "irq cleared", irq, 1'b0);
    edges(1);
    chk("R5", "irq stays clear", irq, 1'b0);
  endtask

  task automatic t_mask();
    irq_en = 1'b0;
    do_load(8'd2, 1'b0);
    edges(2);
    chk("R6", "masked irq", irq, 1'b0);
    chk("R6", "done masked", done, 1'b1);
    @(negedge clk); irq_en = 1'b1;
    #1;
    chk("R6", "unmasked irq", irq, 1'b1);
    clear_irq();
  endtask

  task automatic t_coincide();
    do_load(8'd2, 1'b0);
    edges(1);
    @(negedge clk); fall = 1'b1; irq_clr = 1'b1;
    @(negedge clk); fall = 1'b0; irq_clr = 1'b0;
    chk("R7", "set beats clear", irq, 1'b1);
    clear_irq();
    chk("R7", "later clear", irq, 1'b0);
  endtask

  task automatic t_zero();
    do_load(8'd0, 1'b0);
    chk("R3", "bypass", bypass, 1'b1);
    chk("R3", "shift_en", shift_en, 1'b0);
    edges(5);
    chk("R3", "no done", done, 1'b0);
    chk("R3", "no irq", irq, 1'b0);
  endtask

  task automatic t_reload();
    do_load(8'd5, 1'b0);
    edges(2);
    do_load(8'd2, 1'b0);
    edges(1);
    chk("R8", "reload restarts", shift_en, 1'b1);
    edges(1);
    chk("R8", "reload completes", done, 1'b1);
    clear_irq();
    do_load(8'd2, 1'b1);
    edges(1);
    chk("R8", "edge with load ignored", shift_en, 1'b1);
    edges(1);
    chk("R8", "done after 2", done, 1'b1);
    clear_irq();
  endtask

  task automatic t_restart();
    do_load(8'd2, 1'b0);
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    chk("R9", "shift_en held off", shift_en, 1'b0);
    edges(1);
    chk("R9", "excluded edge", shift_en, 1'b1);
    chk("R9", "not done", done, 1'b0);
    edges(1);
    chk("R9", "one counted", shift_en, 1'b1);
    edges(1);
    chk("R9", "done after skip", done, 1'b1);
    clear_irq();
    do_load(8'd3, 1'b0);
    edges(1);
    @(negedge clk); restart = 1'b1;
    @(negedge clk); restart = 1'b0;
    chk("R9", "late restart ignored", shift_en, 1'b1);
    edges(2);
    chk("R9", "late restart done", done, 1'b1);
    clear_irq();
  endtask

  task automatic t_max();
    do_load(8'd255, 1'b0);
    edges(254);
    chk("R10", "254 edges running", shift_en, 1'b1);
    chk("R10", "254 edges irq", irq, 1'b0);
    edges(1);
    chk("R10", "255 edges done", done, 1'b1);
    chk("R10", "255 edges irq", irq, 1'b1);
    clear_irq();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_mask();
    t_coincide();
    t_zero();
    t_reload();
    t_restart();
    t_max();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule